// File: doc/BRIEF.md
# Serial Bit-Error-Rate Receive Checker

This block watches a received serial bit stream, one bit per cycle in which the valid strobe is high, and compares it against a repeating 32-bit expected pattern. The pattern is consumed least significant bit first. The checker first hunts for the pattern's phase in the incoming stream. Once it has locked, it counts every received bit and every bit that differs from the expected one. Both counts are kept until software-side logic clears them.

The block runs a two-state machine. In state SEARCH it shifts received bits into a 32-bit history. When the 32 most recent bits equal some rotation of the pattern, it takes transition ACQUIRE into LOCKED and aims its pattern pointer at the matching phase. In LOCKED it compares each bit and tracks the errors seen in the last 64 received bits. It returns to SEARCH in two cases. Transition LOSE fires when that window holds six or more errors. Transition RESYNC fires on a rising edge of the resync request. Any toggle of the clear control, rising or falling, empties both counters and both overflow flags.

Both counters saturate and do not wrap. Reaching the top value raises a sticky overflow flag.

Top module: `bert_rx_checker`

## Requirements
- R1: After reset `in_sync` is 0, both counters are 0 and both overflow flags are 0.
- R2: In SEARCH, `in_sync` rises in the cycle after the valid bit that completes 32 consecutive received bits equal to a rotation of `pattern`, where bit i of the history matches pattern bit (k+i) mod 32 and the oldest bit is at position 0. Fewer matching bits, or a non-matching stream, leave it low.
- R3: `bit_count` rises by one in the cycle after each valid bit received while `in_sync` is 1. Bits received in SEARCH do not change the counters, and neither do cycles with `rx_valid` low.
- R4: While locked, the expected bit is taken from `pattern` LSB-first, continuing from the locked phase. `err_count` rises by one after each valid bit that differs from it.
- R5: `bit_count` saturates at its all-ones value. `bit_ovf` is set when the count reaches that value and stays set until the next clear.
- R6: `err_count` saturates at its all-ones value. `err_ovf` is set when the count reaches that value and stays set until the next clear.
- R7: In LOCKED, when the last 64 received bits, including the current one, hold 6 or more errors, the block returns to SEARCH in the next cycle. That bit is still counted. The counters then hold. Five errors in a window keep the lock.
- R8: A change of `latch_ctl` between consecutive cycles, in either direction, zeroes both counters and both flags in the next cycle. The clear takes priority over an increment in the same cycle.
- R9: A rising edge of `resync_req` forces SEARCH in the next cycle and keeps the counter values. Holding `resync_req` high does not trigger again, and the block can reacquire while it is held high.
- R10: Each entry into SEARCH restarts the search. A fresh run of 32 bits received after the entry is needed before lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| pattern | input | 32 | Expected repeating pattern, bit 0 first |
| resync_req | input | 1 | Rising edge forces a new search |
| latch_ctl | input | 1 | Any toggle clears counters and flags |
| in_sync | output | 1 | High while locked to the pattern |
| bit_count | output | BIT_W (32) | Saturating received-bit count |
| err_count | output | ERR_W (24) | Saturating errored-bit count |
| bit_ovf | output | 1 | Sticky bit-counter saturation flag |
| err_ovf | output | 1 | Sticky error-counter saturation flag |

## Verification
Counter saturation is the hardest case to reach from the ports. With the full widths it would take billions of locked bits. The bench therefore builds the block with a 9-bit bit counter and a 4-bit error counter. It injects one error every 16 bits, which stays below the six-in-64 loss threshold, so the error counter can reach its top value while the lock holds. It then runs clean bits until the bit counter also saturates. Loss of lock is driven separately with a dense burst in which errors fall on every other bit, so the fifth error keeps the lock and the sixth drops it.

// File: rtl/bert_pkg.sv
package bert_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } bert_state_e;
endpackage

// File: rtl/bert_ctl_edges.sv
module bert_ctl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_req,
    input  logic latch_ctl,
    output logic resync_hit,
    output logic clr
);
    logic resync_q;
    logic latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resync_q <= 1'b0;
            latch_q  <= 1'b0;
        end else begin
            resync_q <= resync_req;
            latch_q  <= latch_ctl;
        end
    end

    always_comb begin
        resync_hit = resync_req & ~resync_q;
        clr        = latch_ctl ^ latch_q;
    end
endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (inc && count != TOP) begin
            count <= count + ONE;
            if (count == TOP - ONE) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
    import bert_pkg::*;
#(
    parameter int PAT_W    = 32,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic [PAT_W-1:0] pattern,
    input  logic             resync_hit,
    output logic             locked,
    output logic             count_en,
    output logic             bit_err
);
    localparam int PTR_W  = $clog2(PAT_W);
    localparam int WC_W   = $clog2(WIN + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PAT_W - 1);
    localparam logic [WC_W-1:0]  THR      = WC_W'(LOSS_THR);

    bert_state_e state_q, state_d;

    logic [PAT_W-1:0]   hist_q, hist_n;
    logic [PTR_W-1:0]   fill_q;
    logic [PTR_W-1:0]   ptr_q, ptr_inc, hit_idx;
    logic [WIN-1:0]     win_q, win_n;
    logic [2*PAT_W-1:0] pat_dbl;
    logic [PAT_W-1:0]   rot_hit;
    logic               fill_full, mism, too_many;
    logic [WC_W-1:0]    win_errs;

    assign pat_dbl = {pattern, pattern};
    assign hist_n  = {rx_bit, hist_q[PAT_W-1:1]};

    // One comparator per candidate phase of the pattern
    for (genvar k = 0; k < PAT_W; k++) begin : g_rot
        assign rot_hit[k] = (hist_n == pat_dbl[k +: PAT_W]);
    end

    always_comb begin
        hit_idx = '0;
        for (int k = PAT_W - 1; k >= 0; k--) begin
            if (rot_hit[k]) hit_idx = PTR_W'(k);
        end
    end

    always_comb begin
        win_errs = '0;
        for (int i = 0; i < WIN; i++) begin
            win_errs = win_errs + WC_W'(win_n[i]);
        end
    end

    assign fill_full = (fill_q == PTR_LAST);
    assign mism      = rx_bit ^ pattern[ptr_q];
    assign win_n     = {win_q[WIN-2:0], mism};
    assign too_many  = (win_errs >= THR);
    assign ptr_inc   = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);

    // Next-state logic: ACQUIRE, LOSE and RESYNC transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: begin
                if (!resync_hit && rx_valid && fill_full && |rot_hit)
                    state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (resync_hit)
                    state_d = ST_SEARCH;
                else if (rx_valid && too_many)
                    state_d = ST_SEARCH;
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    // Search history, phase pointer and error window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
            ptr_q  <= '0;
            win_q  <= '0;
        end else begin
            if (rx_valid) hist_q <= hist_n;
            unique case (state_q)
                ST_SEARCH: begin
                    if (resync_hit) begin
                        fill_q <= '0;
                    end else if (rx_valid) begin
                        if (state_d == ST_LOCKED) begin
                            ptr_q <= hit_idx;
                            win_q <= '0;
                        end else if (!fill_full) begin
                            fill_q <= fill_q + PTR_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (state_d == ST_SEARCH) begin
                        fill_q <= '0;
                    end else if (rx_valid) begin
                        ptr_q <= ptr_inc;
                        win_q <= win_n;
                    end
                end
                default: fill_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        locked   = (state_q == ST_LOCKED);
        count_en = locked && rx_valid;
        bit_err  = count_en && mism;
    end
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker #(
    parameter int PAT_W    = 32,
    parameter int BIT_W    = 32,
    parameter int ERR_W    = 24,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic [PAT_W-1:0] pattern,
    input  logic             resync_req,
    input  logic             latch_ctl,
    output logic             in_sync,
    output logic [BIT_W-1:0] bit_count,
    output logic [ERR_W-1:0] err_count,
    output logic             bit_ovf,
    output logic             err_ovf
);
    logic resync_hit, clr, count_en, bit_err;

    bert_ctl_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync_req (resync_req),
        .latch_ctl  (latch_ctl),
        .resync_hit (resync_hit),
        .clr        (clr)
    );

    bert_sync_fsm #(
        .PAT_W    (PAT_W),
        .WIN      (WIN),
        .LOSS_THR (LOSS_THR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_valid   (rx_valid),
        .pattern    (pattern),
        .resync_hit (resync_hit),
        .locked     (in_sync),
        .count_en   (count_en),
        .bit_err    (bit_err)
    );

    bert_sat_counter #(.W(BIT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (count_en),
        .count (bit_count),
        .ovf   (bit_ovf)
    );

    bert_sat_counter #(.W(ERR_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (bit_err),
        .count (err_count),
        .ovf   (err_ovf)
    );
endmodule

// File: rtl/bert_rx_checker_sva.sv
module bert_rx_checker_sva #(
    parameter int BIT_W = 32,
    parameter int ERR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resync_req,
    input logic             latch_ctl,
    input logic             in_sync,
    input logic [BIT_W-1:0] bit_count,
    input logic [ERR_W-1:0] err_count,
    input logic             bit_ovf,
    input logic             err_ovf
);
    logic lq, rq, tog, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lq <= 1'b0;
            rq <= 1'b0;
        end else begin
            lq <= latch_ctl;
            rq <= resync_req;
        end
    end

    assign tog  = latch_ctl ^ lq;
    assign rise = resync_req & ~rq;

    p_hold_unsynced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !tog) |=> (bit_count == $past(bit_count) && err_count == $past(err_count)));

    p_err_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tog |=> (err_count == $past(err_count) || err_count == ERR_W'($past(err_count) + 1'b1)));

    p_bit_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&bit_count && !tog) |=> &bit_count);

    p_bit_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        &bit_count |-> bit_ovf);

    p_bit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ovf && !tog) |=> bit_ovf);

    p_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&err_count && !tog) |=> &err_count);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !tog) |=> err_ovf);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tog |=> (bit_count == '0 && err_count == '0 && !bit_ovf && !err_ovf));

    p_resync_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !in_sync);
endmodule

bind bert_rx_checker bert_rx_checker_sva #(
    .BIT_W (BIT_W),
    .ERR_W (ERR_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .resync_req (resync_req),
    .latch_ctl  (latch_ctl),
    .in_sync    (in_sync),
    .bit_count  (bit_count),
    .err_count  (err_count),
    .bit_ovf    (bit_ovf),
    .err_ovf    (err_ovf)
);

// File: tb/sim_bert_rx_checker.sv
`timescale 1ns/1ps
module sim_bert_rx_checker;
    localparam int BW = 9;
    localparam int EW = 4;
    localparam logic [31:0] P = 32'h8F3C_19E6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, rx_valid = 1'b0, resync_req = 1'b0, latch_ctl = 1'b0;
    logic in_sync, bit_ovf, err_ovf;
    logic [BW-1:0] bit_count;
    logic [EW-1:0] err_count;

    always #4 clk = ~clk;

    bert_rx_checker #(.BIT_W(BW), .ERR_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .pattern(P), .resync_req(resync_req), .latch_ctl(latch_ctl),
        .in_sync(in_sync), .bit_count(bit_count), .err_count(err_count),
        .bit_ovf(bit_ovf), .err_ovf(err_ovf)
    );

    typedef struct {
        logic          sync;
        logic [BW-1:0] bc;
        logic [EW-1:0] ec;
        logic          bo;
        logic          eo;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0;

    // Requirement-level model state
    logic          m_sync = 0, m_lq = 0, m_rq = 0, m_bo = 0, m_eo = 0;
    logic [31:0]   m_hist = 0;
    int            m_fill = 0, m_ptr = 0, bph = 0;
    logic [63:0]   m_win = 0;
    logic [BW-1:0] m_bc = 0;
    logic [EW-1:0] m_ec = 0;

    task automatic model_step(input logic v, input logic b, input logic rs, input logic lc);
        logic tog, rh, mism, hit;
        logic [31:0] hn;
        int k_hit;
        tog = lc ^ m_lq;
        rh  = rs & ~m_rq;
        m_lq = lc;
        m_rq = rs;
        mism = b ^ P[m_ptr];
        if (tog) begin
            m_bc = '0; m_ec = '0; m_bo = 0; m_eo = 0;
        end else if (v && m_sync) begin
            if (m_bc != '1) begin m_bc = m_bc + 1'b1; if (m_bc == '1) m_bo = 1; end
            if (mism && m_ec != '1) begin m_ec = m_ec + 1'b1; if (m_ec == '1) m_eo = 1; end
        end
        hn = {b, m_hist[31:1]};
        if (!m_sync) begin
            if (rh) m_fill = 0;
            else if (v) begin
                if (m_fill == 31) begin
                    hit = 0; k_hit = 0;
                    for (int k = 31; k >= 0; k--)
                        if (hn == ((P >> k) | (P << (32 - k)))) begin hit = 1; k_hit = k; end
                    if (hit) begin m_sync = 1; m_ptr = k_hit; m_win = '0; end
                end else m_fill++;
            end
        end else begin
            if (rh) begin m_sync = 0; m_fill = 0; end
            else if (v) begin
                m_win = {m_win[62:0], mism};
                if ($countones(m_win) >= 6) begin m_sync = 0; m_fill = 0; end
                else m_ptr = (m_ptr + 1) % 32;
            end
        end
        if (v) m_hist = hn;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input logic v, input logic b, input logic rs, input logic lc, input string tag);
        exp_t e;
        @(negedge clk);
        rx_valid = v; rx_bit = b; resync_req = rs; latch_ctl = lc;
        model_step(v, b, rs, lc);
        e.sync = m_sync; e.bc = m_bc; e.ec = m_ec; e.bo = m_bo; e.eo = m_eo; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send_pat(input int n, input int err_every, input string tag);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = P[bph];
            if (err_every > 0 && (i % err_every) == err_every - 1) b = ~b;
            bph = (bph + 1) % 32;
            step(1'b1, b, resync_req, latch_ctl, tag);
        end
    endtask

    // Monitor: compares outputs shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (in_sync !== e.sync || bit_count !== e.bc || err_count !== e.ec ||
                    bit_ovf !== e.bo || err_ovf !== e.eo) begin
                    n_bad++;
                    $display("FAIL %s: got sync=%0b bc=%0d ec=%0d bo=%0b eo=%0b exp sync=%0b bc=%0d ec=%0d bo=%0b eo=%0b",
                             e.tag, in_sync, bit_count, err_count, bit_ovf, err_ovf,
                             e.sync, e.bc, e.ec, e.bo, e.eo);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (in_sync !== 0 || bit_count !== 0 || err_count !== 0 || bit_ovf !== 0 || err_ovf !== 0) begin
            n_bad++;
            $display("FAIL R1: got sync=%0b bc=%0d ec=%0d exp all zero", in_sync, bit_count, err_count);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R3 idle");
        bph = 5;
        send_pat(31, 0, "R2 partial");
        send_pat(1, 0, "R2 lock");
        send_pat(40, 0, "R3 clean");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R3 valid low");
        send_pat(320, 16, "R4 R6 sparse errors");
        send_pat(200, 0, "R5 saturate");
        // R8: toggle together with a counted bit
        step(1'b1, P[bph], 1'b0, 1'b1, "R8 clear");
        bph = (bph + 1) % 32;
        send_pat(10, 0, "R3 after clear");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8 falling clear");
        send_pat(12, 2, "R7 burst");
        send_pat(20, 0, "R7 held after loss");
        send_pat(31, 0, "R10 partial");
        send_pat(1, 0, "R10 relock");
        send_pat(8, 0, "R3 counting");
        step(1'b1, P[bph], 1'b1, 1'b0, "R9 resync edge");
        bph = (bph + 1) % 32;
        send_pat(40, 0, "R9 level held");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R9 release");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R9 second edge");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R9 release");
        for (int i = 0; i < 40; i++) step(1'b1, ~P[i % 32], 1'b0, 1'b0, "R2 mismatch stream");
        send_pat(40, 0, "R2 reacquire");
        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule